// File: doc/BRIEF.md
# Prioritised Pending-Interrupt Selector

This block keeps one pending flag per interrupt source and, on request from the core, picks the single most urgent eligible source to deliver. Sources raise their flag with a one-cycle set strobe, and software may drop flags with a clear strobe. When the core signals that it can take an interrupt, the block looks at the pending flags together with two enable bits. It then issues a one-cycle delivery strobe and a 4-bit cause code one cycle later.

There are three eligibility classes. Reset and machine check are always eligible. The critical external input needs the critical enable. The other nine sources need the general enable. Within this arrangement the priority is fixed and matches the cause numbering, with the lowest code winning. Delivering a source acknowledges it, which clears its flag. The two external inputs are level-held, so they stay pending until software or the source removes them.

Top module: `prio_irq_selector`

## Requirements
- R1: After reset every pending flag reads 0 and deliver_o is 0.
- R2: A 1 on set_i[k] makes pending_o[k] read 1 from the next cycle. Bit k belongs to the source whose cause code is k.
- R3: A 1 on clr_i[k] clears pending_o[k] on the next cycle, except when set_i[k] is also 1 in that cycle, in which case the flag ends up 1.
- R4: Reset (code 0) and machine check (code 1) are delivered whatever the enables are, and reset wins over machine check.
- R5: Critical external (code 2) is eligible only while ce_en_i is 1. It takes precedence over every general-class source. While ce_en_i is 0, general-class sources are still delivered.
- R6: The general-class sources are eligible only while ee_en_i is 1. Among them the order, highest first, is: watchdog 3, critical doorbell 4, fixed-interval timer 5, programmable interval timer 6, decrementer 7, external 8, doorbell 9, performance monitor 10, thermal 11.
- R7: When ready_i is 1 in a cycle with an eligible flag, deliver_o is 1 in the following cycle with cause_o set to the winning code. Without ready_i, or with nothing eligible, deliver_o stays 0.
- R8: Delivery clears only the delivered flag. All other flags keep their values.
- R9: Delivering code 2 or code 8 leaves its flag set.
- R10: A set strobe on the flag being delivered in the same cycle leaves that flag at 1.
- R11: Each ready_i cycle produces at most one delivery, and deliver_o is high for a single cycle per ready_i cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_i | input | 12 | Per-source set strobes |
| clr_i | input | 12 | Per-source software clear strobes |
| ce_en_i | input | 1 | Critical-class enable |
| ee_en_i | input | 1 | General-class enable |
| ready_i | input | 1 | Core can accept an interrupt this cycle |
| deliver_o | output | 1 | One-cycle delivery strobe |
| cause_o | output | 4 | Code of the delivered source |
| pending_o | output | 12 | Current pending flags |

## Verification
The hardest case to reach is the collision between a set strobe and the acknowledge of the same flag. It needs the set pulse and the ready pulse on exactly the same edge while that flag is the current winner. The bench drives both in one task, from the same falling edge, after it has cleared every flag of higher priority. A related case is starvation behind a held external input. Here the bench delivers code 8 twice with lower flags pending, then clears it by software so that the doorbell and the remaining sources can drain.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
   localparam int unsigned SRC_COUNT = 12;
   localparam int unsigned CAUSE_W   = 4;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_RESET   = 4'd0,
      CAUSE_MCHK    = 4'd1,
      CAUSE_CRITEXT = 4'd2,
      CAUSE_WDOG    = 4'd3,
      CAUSE_CDBELL  = 4'd4,
      CAUSE_FIXTMR  = 4'd5,
      CAUSE_PROGTMR = 4'd6,
      CAUSE_DECR    = 4'd7,
      CAUSE_EXTIN   = 4'd8,
      CAUSE_DBELL   = 4'd9,
      CAUSE_PERF    = 4'd10,
      CAUSE_THERM   = 4'd11
   } cause_e;

   // class membership per source bit
   localparam logic [SRC_COUNT-1:0] DEF_ALWAYS_MASK = 12'h003;
   localparam logic [SRC_COUNT-1:0] DEF_CRIT_MASK   = 12'h004;
   localparam logic [SRC_COUNT-1:0] DEF_GEN_MASK    = 12'hFF8;
   // sources whose flag survives delivery
   localparam logic [SRC_COUNT-1:0] DEF_HOLD_MASK   = 12'h104;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned             N_SRC     = 12,
   parameter logic [N_SRC-1:0]        HOLD_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   input  logic [N_SRC-1:0] ack_i,
   output logic [N_SRC-1:0] pend_o
);
   for (genvar k = 0; k < N_SRC; k++) begin : g_bit
      logic flag_q;
      logic drop;

      if (HOLD_MASK[k]) begin : g_held
         assign drop = clr_i[k];
      end else begin : g_acked
         assign drop = clr_i[k] | ack_i[k];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)        flag_q <= 1'b0;
         else if (set_i[k]) flag_q <= 1'b1;
         else if (drop)     flag_q <= 1'b0;
      end

      assign pend_o[k] = flag_q;

      // R10 / R3: a set strobe always leaves the flag raised
      a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[k] |=> pend_o[k]);

      if (HOLD_MASK[k]) begin : g_chk_hold
         a_r9_held_stays: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[k] && !clr_i[k]) |=> pend_o[k]);
      end else begin : g_chk_ack
         a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[k] && !set_i[k]) |=> !pend_o[k]);
      end

      // R8: an unacknowledged, untouched flag keeps its value
      a_r8_untouched: assert property (@(posedge clk) disable iff (!rst_n)
         (!ack_i[k] && !set_i[k] && !clr_i[k]) |=> $stable(pend_o[k]));
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned      N_SRC       = 12,
   parameter int unsigned      CODE_W      = 4,
   parameter logic [N_SRC-1:0] ALWAYS_MASK = '0,
   parameter logic [N_SRC-1:0] CRIT_MASK   = '0,
   parameter logic [N_SRC-1:0] GEN_MASK    = '0
) (
   input  logic [N_SRC-1:0]  pend_i,
   input  logic              ce_en_i,
   input  logic              ee_en_i,
   output logic [N_SRC-1:0]  grant_o,
   output logic              any_o,
   output logic [CODE_W-1:0] code_o
);
   logic [N_SRC-1:0] elig;

   for (genvar k = 0; k < N_SRC; k++) begin : g_elig
      if (ALWAYS_MASK[k]) begin : g_nmi
         assign elig[k] = pend_i[k];
      end else if (CRIT_MASK[k]) begin : g_crit
         assign elig[k] = pend_i[k] & ce_en_i;
      end else begin : g_gen
         assign elig[k] = pend_i[k] & ee_en_i;
      end
   end

   // lowest index wins; index order equals priority order
   always_comb begin
      logic taken;
      taken   = 1'b0;
      grant_o = '0;
      code_o  = '0;
      for (int k = 0; k < N_SRC; k++) begin
         if (elig[k] && !taken) begin
            grant_o[k] = 1'b1;
            code_o     = CODE_W'(k);
            taken      = 1'b1;
         end
      end
   end

   assign any_o = |elig;
endmodule

// File: rtl/irq_deliver_stage.sv
module irq_deliver_stage #(
   parameter int unsigned N_SRC  = 12,
   parameter int unsigned CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ready_i,
   input  logic              any_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic [N_SRC-1:0]  grant_i,
   output logic [N_SRC-1:0]  ack_o,
   output logic              deliver_o,
   output logic [CODE_W-1:0] cause_o
);
   logic              fire;
   logic              deliver_q;
   logic [CODE_W-1:0] cause_q;

   assign fire  = ready_i & any_i;
   assign ack_o = grant_i & {N_SRC{ready_i}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         deliver_q <= 1'b0;
         cause_q   <= '0;
      end else begin
         deliver_q <= fire;
         if (fire) cause_q <= code_i;
      end
   end

   assign deliver_o = deliver_q;
   assign cause_o   = cause_q;

   // R11: no more than one acknowledge per evaluation
   a_r11_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_o));
   // R11: a strobe never lasts past the ready cycle that caused it
   a_r11_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver_o && !$past(ready_i)) |-> 1'b0);
endmodule

// File: rtl/prio_irq_selector.sv
module prio_irq_selector
   import irq_sel_pkg::*;
#(
   parameter int unsigned          N_SRC       = SRC_COUNT,
   parameter int unsigned          CODE_W      = CAUSE_W,
   parameter logic [N_SRC-1:0]     ALWAYS_MASK = DEF_ALWAYS_MASK,
   parameter logic [N_SRC-1:0]     CRIT_MASK   = DEF_CRIT_MASK,
   parameter logic [N_SRC-1:0]     GEN_MASK    = DEF_GEN_MASK,
   parameter logic [N_SRC-1:0]     HOLD_MASK   = DEF_HOLD_MASK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  set_i,
   input  logic [N_SRC-1:0]  clr_i,
   input  logic              ce_en_i,
   input  logic              ee_en_i,
   input  logic              ready_i,
   output logic              deliver_o,
   output logic [CODE_W-1:0] cause_o,
   output logic [N_SRC-1:0]  pending_o
);
   localparam logic [N_SRC-1:0] CLASS_OVERLAP =
      (ALWAYS_MASK & CRIT_MASK) | (ALWAYS_MASK & GEN_MASK) | (CRIT_MASK & GEN_MASK);
   localparam logic [N_SRC-1:0] CLASS_UNION = ALWAYS_MASK | CRIT_MASK | GEN_MASK;

   if (N_SRC > (1 << CODE_W)) begin : g_bad_width
      $error("cause code too narrow for source count");
   end
   if (CLASS_OVERLAP != '0) begin : g_bad_overlap
      $error("a source sits in more than one enable class");
   end
   if (CLASS_UNION != {N_SRC{1'b1}}) begin : g_bad_cover
      $error("a source has no enable class");
   end

   logic [N_SRC-1:0]  pend;
   logic [N_SRC-1:0]  grant;
   logic [N_SRC-1:0]  ack;
   logic              any_elig;
   logic [CODE_W-1:0] win_code;

   irq_pend_bank #(.N_SRC(N_SRC), .HOLD_MASK(HOLD_MASK)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr_i),
      .ack_i(ack), .pend_o(pend));

   irq_prio_pick #(.N_SRC(N_SRC), .CODE_W(CODE_W), .ALWAYS_MASK(ALWAYS_MASK),
                   .CRIT_MASK(CRIT_MASK), .GEN_MASK(GEN_MASK)) u_pick (
      .pend_i(pend), .ce_en_i(ce_en_i), .ee_en_i(ee_en_i),
      .grant_o(grant), .any_o(any_elig), .code_o(win_code));

   irq_deliver_stage #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_dlv (
      .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .any_i(any_elig),
      .code_i(win_code), .grant_i(grant), .ack_o(ack),
      .deliver_o(deliver_o), .cause_o(cause_o));

   assign pending_o = pend;

   // R7: deliveries only follow a ready cycle
   a_r7_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      deliver_o |-> $past(ready_i));
   // R6: general-class causes require the general enable
   a_r6_gen_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver_o && GEN_MASK[cause_o]) |-> $past(ee_en_i));
   // R5: critical-class causes require the critical enable
   a_r5_crit_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver_o && CRIT_MASK[cause_o]) |-> $past(ce_en_i));
   // R4: an always-class flag pending at ready time is what gets delivered
   a_r4_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_i && (pend & ALWAYS_MASK) != '0) |=> (deliver_o && ALWAYS_MASK[cause_o]));
endmodule

// File: tb/tb_prio_irq_selector.sv
module tb_prio_irq_selector;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] set_i = '0;
   logic [11:0] clr_i = '0;
   logic        ce_en_i = 1'b0;
   logic        ee_en_i = 1'b0;
   logic        ready_i = 1'b0;
   logic        deliver_o;
   logic [3:0]  cause_o;
   logic [11:0] pending_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   prio_irq_selector dut (.*);

   always #4 clk = ~clk;

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic raise(logic [11:0] m);
      set_i = m; @(negedge clk); set_i = '0;
   endtask

   task automatic drop(logic [11:0] m);
      clr_i = m; @(negedge clk); clr_i = '0;
   endtask

   // one ready pulse, then check strobe, cause and flags
   task automatic ask(string req, bit exp_dlv, int exp_cause, logic [11:0] exp_pend);
      ready_i = 1'b1; @(negedge clk); ready_i = 1'b0;
      chk(req, "deliver", deliver_o, exp_dlv);
      if (exp_dlv) chk(req, "cause", cause_o, exp_cause);
      chk(req, "pending", pending_o, exp_pend);
   endtask

   task automatic t_reset;
      chk("R1", "pending after reset", pending_o, 0);
      chk("R1", "deliver after reset", deliver_o, 0);
   endtask

   task automatic t_full_drain;
      ce_en_i = 0; ee_en_i = 0;
      raise(12'hFFF);
      chk("R2", "all set", pending_o, 12'hFFF);
      ask("R4", 1, 0, 12'hFFE);
      chk("R11", "strobe one cycle", deliver_o, 1);
      @(negedge clk);
      chk("R11", "strobe dropped", deliver_o, 0);
      ask("R4", 1, 1, 12'hFFC);
      ask("R5", 0, 0, 12'hFFC);
      ce_en_i = 1;
      ask("R9", 1, 2, 12'hFFC);
      ce_en_i = 0; ee_en_i = 1;
      ask("R6", 1, 3, 12'hFF4);
      ask("R6", 1, 4, 12'hFE4);
      ask("R6", 1, 5, 12'hFC4);
      ask("R6", 1, 6, 12'hF84);
      ask("R8", 1, 7, 12'hF04);
      ask("R9", 1, 8, 12'hF04);
      ask("R9", 1, 8, 12'hF04);
      drop(12'h100);
      chk("R3", "sw clear", pending_o, 12'hE04);
      ask("R6", 1, 9, 12'hC04);
      ask("R6", 1, 10, 12'h804);
      ask("R6", 1, 11, 12'h004);
      ask("R5", 0, 0, 12'h004);
      drop(12'h004);
      chk("R3", "sw clear crit", pending_o, 0);
   endtask

   task automatic t_nmi_with_enables;
      ce_en_i = 1; ee_en_i = 1;
      raise(12'h802);
      ask("R4", 1, 1, 12'h800);
      ask("R6", 1, 11, 12'h000);
   endtask

   task automatic t_crit_before_gen;
      raise(12'h00C);
      ask("R5", 1, 2, 12'h00C);
      ce_en_i = 0;
      ask("R5", 1, 3, 12'h004);
      drop(12'h004);
      ce_en_i = 1;
   endtask

   task automatic t_set_vs_ack;
      raise(12'h080);
      set_i = 12'h080; ready_i = 1; @(negedge clk); set_i = '0; ready_i = 0;
      chk("R10", "deliver", deliver_o, 1);
      chk("R10", "cause", cause_o, 7);
      chk("R10", "flag kept", pending_o, 12'h080);
      ask("R8", 1, 7, 12'h000);
   endtask

   task automatic t_set_vs_clr;
      set_i = 12'h020; clr_i = 12'h020; @(negedge clk); set_i = '0; clr_i = '0;
      chk("R3", "set beats clear", pending_o, 12'h020);
      drop(12'h020);
   endtask

   task automatic t_no_ready;
      raise(12'h200);
      repeat (3) @(negedge clk);
      chk("R7", "idle no strobe", deliver_o, 0);
      chk("R7", "idle flags", pending_o, 12'h200);
      ee_en_i = 0;
      ask("R6", 0, 0, 12'h200);
      ee_en_i = 1;
      ask("R7", 1, 9, 12'h000);
      ask("R7", 0, 0, 12'h000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset;
      t_full_drain;
      t_nmi_with_enables;
      t_crit_before_gen;
      t_set_vs_ack;
      t_set_vs_clr;
      t_no_ready;
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule